// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block is the control state machine in front of a successive-approximation converter. A start pulse launches a sequence over the channels chosen by one of two 12-bit masks: one for slave-initiated sequences and one for master-initiated sequences. For each chosen channel the block opens an acquisition window (`sample_en`), issues a one-cycle convert strobe, and waits for the converter's done/result handshake. Optionally it repeats the conversion 4, 8 or 16 times and writes only the averaged value to the result port.

A programmable power-up and settling delay comes before the first conversion, before each conversion of the two coordinate channels (0 and 1), and once more after the last result. An external stop-acquisition input of selectable polarity can hold off the start of any acquisition. It is only looked at once a delay has run out. The ADC and reference power enables follow a 2-bit power mode and whether a sequence is running.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Channel k (0..10) is chosen by mask bit 11-k, and mask bit 0 is ignored. Chosen channels are converted in ascending channel order, with exactly one result write per chosen channel and `res_chan` equal to k. Unchosen channels take no cycles: a channel other than 0 or 1 starts its window on the second cycle after the previous result write.
- R2: `cfg_delay_sel` codes 00, 01, 10 and 11 give a delay N of 1, 256, 2048 and 16384 cycles. The first `sample_en` of a sequence rises N+1 cycles after `busy` rises.
- R3: When channel 0 or 1 is not the first channel of the sequence, its window opens N+1 cycles after the previous result write. After the last result write, `busy` stays high for exactly N more cycles.
- R4: With `cfg_hold_pol`=1, `hold_in` high is the active level; with 0, `hold_in` low is active. While the hold is active no acquisition window opens. The sequence resumes when the hold goes inactive.
- R5: A hold that becomes active during a delay and goes inactive again before the delay ends does not lengthen the sequence.
- R6: `cfg_acq_sel` codes 00..11 keep `sample_en` high for 4, 8, 16 or 32 cycles. `conv_start` is a single-cycle pulse in the cycle right after the window.
- R7: `cfg_avg_sel` codes 00..11 run 1, 4, 8 or 16 conversions per channel. The written result is their sum, kept in 16 bits, shifted right by 0, 2, 3 or 4.
- R8: `cfg_pwr_mode` 00 turns both enables off. Mode 01 turns both on only while `busy`. Mode 10 keeps both on. Mode 11 keeps the reference on and turns the ADC on only while `busy`.
- R9: A start is ignored in power mode 00. A master start (`start_master`=1) is ignored in mode 10, while a slave start is accepted in mode 10.
- R10: A master start scans `master_mask` and a slave start scans `slave_mask`.
- R11: `busy` rises in the cycle after an accepted start and falls when the trailing delay ends. Every result write happens while `busy` is high. A start with no chosen channel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_delay_sel | input | 2 | Power-up/settling delay code |
| cfg_acq_sel | input | 2 | Acquisition window code |
| cfg_avg_sel | input | 2 | Averaging count code |
| cfg_pwr_mode | input | 2 | Power mode code |
| cfg_hold_pol | input | 1 | Stop-acquisition polarity, 1 = active high |
| slave_mask | input | 12 | Channel mask for slave-initiated sequences |
| master_mask | input | 12 | Channel mask for master-initiated sequences |
| start | input | 1 | Start pulse, taken only when idle |
| start_master | input | 1 | With `start`: 1 selects the master sequence |
| hold_in | input | 1 | Asynchronous stop-acquisition input |
| conv_done | input | 1 | Converter finished, `conv_data` valid |
| conv_data | input | 12 | Converter result |
| chan_sel | output | 4 | Channel being sampled or converted |
| sample_en | output | 1 | Acquisition window |
| conv_start | output | 1 | One-cycle convert strobe |
| res_we | output | 1 | Result write strobe |
| res_chan | output | 4 | Channel of the written result |
| res_data | output | 12 | Averaged result |
| adc_pwr_en | output | 1 | ADC power enable |
| ref_pwr_en | output | 1 | Reference power enable |
| busy | output | 1 | Sequence in progress |

## Verification
The checker watches on every cycle that each window opens only with the synchronized hold inactive and lasts the coded length. It also checks that the convert strobe is one cycle long and directly follows the window, that both supplies are on while sampling, that refused starts leave the block idle, and that result writes happen only while busy. Only the bench scenarios can show the cycle-exact delays before the first channel, before the coordinate channels and after the last result, the scan order and the skipping of unchosen channels. The same holds for the averaged values, the choice between the two masks, and a hold pulse being ignored when it falls inside a delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DLY,
      ST_WAIT,
      ST_ACQ,
      ST_CONV,
      ST_CWAIT,
      ST_NEXT,
      ST_TAIL
   } seq_state_t;

   localparam logic [1:0] PWR_OFF      = 2'b00;
   localparam logic [1:0] PWR_AUTO_ALL = 2'b01;
   localparam logic [1:0] PWR_ON       = 2'b10;
   localparam logic [1:0] PWR_AUTO_ADC = 2'b11;

   // conversions per channel for an averaging code
   function automatic int unsigned avg_count(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   // right shift that turns the sum into the mean
   function automatic logic [2:0] avg_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd0;
         2'd1:    return 3'd2;
         2'd2:    return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
   parameter int NUM_CH = 11,
   parameter int CH_W   = 4
) (
   input  logic [NUM_CH-1:0] pend,
   output logic              found,
   output logic [CH_W-1:0]   chan
);
   // lowest pending channel wins
   always_comb begin
      found = 1'b0;
      chan  = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         if (pend[k]) begin
            found = 1'b1;
            chan  = CH_W'(k);
         end
      end
   end
endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
   parameter int DATA_W = 12,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic [DATA_W-1:0] din,
   input  logic [2:0]        shift,
   output logic [DATA_W-1:0] mean
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (clr)  acc_q <= '0;
      else if (add)  acc_q <= acc_q + ACC_W'(din);
   end

   assign shifted = acc_q >> shift;
   assign mean    = shifted[DATA_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int NUM_CH    = 11,
   parameter int MASK_W    = 12,
   parameter int COORD_CH  = 2,
   parameter int HOLD_SYNC = 2,
   parameter int DLY_LEN0  = 1,
   parameter int DLY_LEN1  = 256,
   parameter int DLY_LEN2  = 2048,
   parameter int DLY_LEN3  = 16384,
   parameter int ACQ_BASE  = 4,
   parameter int AVG_MAX   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_delay_sel,
   input  logic [1:0]        cfg_acq_sel,
   input  logic [1:0]        cfg_avg_sel,
   input  logic [1:0]        cfg_pwr_mode,
   input  logic              cfg_hold_pol,
   input  logic [11:0]       slave_mask,
   input  logic [11:0]       master_mask,
   input  logic              start,
   input  logic              start_master,
   input  logic              hold_in,
   input  logic              conv_done,
   input  logic [11:0]       conv_data,
   output logic [3:0]        chan_sel,
   output logic              sample_en,
   output logic              conv_start,
   output logic              res_we,
   output logic [3:0]        res_chan,
   output logic [11:0]       res_data,
   output logic              adc_pwr_en,
   output logic              ref_pwr_en,
   output logic              busy
);
   localparam int CH_W    = $clog2(NUM_CH);
   localparam int DLY_W   = $clog2(DLY_LEN3 + 1);
   localparam int ACQ_W   = $clog2(ACQ_BASE * 8 + 1);
   localparam int SMP_W   = $clog2(AVG_MAX + 1);
   localparam int ACC_W   = DATA_W + $clog2(AVG_MAX);

   // elaboration-time parameter checks
   generate
      if (MASK_W != NUM_CH + 1) begin : g_bad_mask
         $error("MASK_W must be NUM_CH + 1");
      end
      if (CH_W != 4 || DATA_W != 12 || MASK_W != 12) begin : g_bad_ports
         $error("port widths assume 11 channels of 12-bit data");
      end
      if (!(DLY_LEN0 >= 1 && DLY_LEN0 < DLY_LEN1 && DLY_LEN1 < DLY_LEN2 && DLY_LEN2 < DLY_LEN3)) begin : g_bad_dly
         $error("delay lengths must be rising and at least 1");
      end
      if (AVG_MAX != 16 || ACQ_BASE < 1) begin : g_bad_avg
         $error("averaging table tops out at 16, window base must be positive");
      end
      if (COORD_CH < 0 || COORD_CH > NUM_CH) begin : g_bad_coord
         $error("COORD_CH out of range");
      end
   endgenerate

   seq_state_t state_q;

   logic [NUM_CH-1:0] slave_pend, master_pend, pend_in, pend_q, pend_rest, pick_src;
   logic [CH_W-1:0]   chan_q, pick_chan;
   logic              pick_found;
   logic [1:0]        dly_sel_q, acq_sel_q, avg_sel_q, dly_sel_use;
   logic [SMP_W-1:0]  smp_cnt_q, smp_next, navg;
   logic              hold_sync, hold_act;
   logic              accept, coord_next;
   logic              dly_load, dly_dec, dly_zero;
   logic              acq_load, acq_dec, acq_zero;
   logic [DLY_W-1:0]  dly_val;
   logic [ACQ_W-1:0]  acq_val;
   logic [DATA_W-1:0] mean;
   logic              unused_mask_lsb;

   // mask bit (MASK_W-1-k) chooses channel k
   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_remap
         assign slave_pend[k]  = slave_mask[MASK_W-1-k];
         assign master_pend[k] = master_mask[MASK_W-1-k];
      end
   endgenerate
   assign unused_mask_lsb = slave_mask[0] ^ master_mask[0];

   assign pend_in   = start_master ? master_pend : slave_pend;
   assign pend_rest = pend_q & ~(NUM_CH'(1) << chan_q);
   assign pick_src  = (state_q == ST_IDLE) ? pend_in : pend_rest;

   adc_seq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .pend  (pick_src),
      .found (pick_found),
      .chan  (pick_chan)
   );

   // stop-acquisition input, synchronized then polarity applied
   adc_seq_sync #(.STAGES(HOLD_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (hold_in),
      .dout  (hold_sync)
   );
   assign hold_act = cfg_hold_pol ? hold_sync : ~hold_sync;

   // start acceptance
   always_comb begin
      accept = start && (|pend_in);
      if (cfg_pwr_mode == PWR_OFF)                  accept = 1'b0;
      if (cfg_pwr_mode == PWR_ON && start_master)   accept = 1'b0;
   end

   assign coord_next = pick_found && (int'(pick_chan) < COORD_CH);

   // delay timer
   assign dly_sel_use = (state_q == ST_IDLE) ? cfg_delay_sel : dly_sel_q;
   always_comb begin
      case (dly_sel_use)
         2'd0:    dly_val = DLY_W'(DLY_LEN0 - 1);
         2'd1:    dly_val = DLY_W'(DLY_LEN1 - 1);
         2'd2:    dly_val = DLY_W'(DLY_LEN2 - 1);
         default: dly_val = DLY_W'(DLY_LEN3 - 1);
      endcase
   end
   assign dly_load = (state_q == ST_IDLE && accept) ||
                     (state_q == ST_NEXT && (!pick_found || coord_next));
   assign dly_dec  = (state_q == ST_DLY) || (state_q == ST_TAIL);

   adc_seq_timer #(.CNT_W(DLY_W)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .load_val (dly_val),
      .dec      (dly_dec),
      .zero     (dly_zero)
   );

   // acquisition timer
   assign acq_val  = ACQ_W'((ACQ_BASE << acq_sel_q) - 1);
   assign acq_load = (state_q == ST_WAIT) && !hold_act;
   assign acq_dec  = (state_q == ST_ACQ);

   adc_seq_timer #(.CNT_W(ACQ_W)) u_acq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acq_load),
      .load_val (acq_val),
      .dec      (acq_dec),
      .zero     (acq_zero)
   );

   // averaging
   adc_seq_avg #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_avg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_NEXT),
      .add   (state_q == ST_CWAIT && conv_done),
      .din   (conv_data),
      .shift (avg_shift(avg_sel_q)),
      .mean  (mean)
   );

   assign navg     = SMP_W'(avg_count(avg_sel_q));
   assign smp_next = smp_cnt_q + 1'b1;

   // sequencing state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pend_q    <= '0;
         chan_q    <= '0;
         dly_sel_q <= '0;
         acq_sel_q <= '0;
         avg_sel_q <= '0;
         smp_cnt_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  pend_q    <= pend_in;
                  chan_q    <= pick_chan;
                  dly_sel_q <= cfg_delay_sel;
                  acq_sel_q <= cfg_acq_sel;
                  avg_sel_q <= cfg_avg_sel;
                  smp_cnt_q <= '0;
                  state_q   <= ST_DLY;
               end
            end
            ST_DLY:  if (dly_zero)  state_q <= ST_WAIT;
            ST_WAIT: if (!hold_act) state_q <= ST_ACQ;
            ST_ACQ:  if (acq_zero)  state_q <= ST_CONV;
            ST_CONV: state_q <= ST_CWAIT;
            ST_CWAIT: begin
               if (conv_done) begin
                  smp_cnt_q <= smp_next;
                  state_q   <= (smp_next >= navg) ? ST_NEXT : ST_WAIT;
               end
            end
            ST_NEXT: begin
               smp_cnt_q <= '0;
               pend_q    <= pend_rest;
               if (pick_found) begin
                  chan_q  <= pick_chan;
                  state_q <= coord_next ? ST_DLY : ST_WAIT;
               end else begin
                  state_q <= ST_TAIL;
               end
            end
            ST_TAIL: if (dly_zero) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // outputs
   assign busy       = (state_q != ST_IDLE);
   assign chan_sel   = chan_q;
   assign sample_en  = (state_q == ST_ACQ);
   assign conv_start = (state_q == ST_CONV);
   assign res_we     = (state_q == ST_NEXT);
   assign res_chan   = chan_q;
   assign res_data   = mean;

   always_comb begin
      case (cfg_pwr_mode)
         PWR_AUTO_ALL: begin adc_pwr_en = busy; ref_pwr_en = busy; end
         PWR_ON:       begin adc_pwr_en = 1'b1; ref_pwr_en = 1'b1; end
         PWR_AUTO_ADC: begin adc_pwr_en = busy; ref_pwr_en = 1'b1; end
         default:      begin adc_pwr_en = 1'b0; ref_pwr_en = 1'b0; end
      endcase
   end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int NUM_CH = 11
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_acq_sel,
   input logic [1:0] cfg_pwr_mode,
   input logic       start,
   input logic       start_master,
   input logic       hold_act,
   input logic       sample_en,
   input logic       conv_start,
   input logic       res_we,
   input logic [3:0] res_chan,
   input logic       adc_pwr_en,
   input logic       ref_pwr_en,
   input logic       busy
);
   logic [6:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_len <= '0;
      else if (sample_en) run_len <= run_len + 1'b1;
      else                run_len <= '0;
   end

   assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sample_en) |-> (run_len == (7'd4 << $past(cfg_acq_sel))));

   assert_conv_follows_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> ($past(sample_en) && !sample_en));

   assert_conv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_hold_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_en) |-> !$past(hold_act));

   assert_sample_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> (adc_pwr_en && ref_pwr_en));

   assert_on_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pwr_mode == 2'b10) |-> (adc_pwr_en && ref_pwr_en));

   assert_off_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && cfg_pwr_mode == 2'b00) |=> !busy);

   assert_master_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && start_master && cfg_pwr_mode == 2'b10) |=> !busy);

   assert_write_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> busy);

   assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> (32'(res_chan) < NUM_CH));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_acq_sel  (cfg_acq_sel),
   .cfg_pwr_mode (cfg_pwr_mode),
   .start        (start),
   .start_master (start_master),
   .hold_act     (hold_act),
   .sample_en    (sample_en),
   .conv_start   (conv_start),
   .res_we       (res_we),
   .res_chan     (res_chan),
   .adc_pwr_en   (adc_pwr_en),
   .ref_pwr_en   (ref_pwr_en),
   .busy         (busy)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_delay_sel = 2'd0, cfg_acq_sel = 2'd0, cfg_avg_sel = 2'd0, cfg_pwr_mode = 2'd0;
   logic        cfg_hold_pol = 1'b1;
   logic [11:0] slave_mask = '0, master_mask = '0;
   logic        start = 1'b0, start_master = 1'b0, hold_in = 1'b0;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;
   logic [3:0]  chan_sel, res_chan;
   logic        sample_en, conv_start, res_we, adc_pwr_en, ref_pwr_en, busy;
   logic [11:0] res_data;

   int n_chk = 0, n_err = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   adc_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_delay_sel(cfg_delay_sel), .cfg_acq_sel(cfg_acq_sel), .cfg_avg_sel(cfg_avg_sel),
      .cfg_pwr_mode(cfg_pwr_mode), .cfg_hold_pol(cfg_hold_pol),
      .slave_mask(slave_mask), .master_mask(master_mask),
      .start(start), .start_master(start_master), .hold_in(hold_in),
      .conv_done(conv_done), .conv_data(conv_data),
      .chan_sel(chan_sel), .sample_en(sample_en), .conv_start(conv_start),
      .res_we(res_we), .res_chan(res_chan), .res_data(res_data),
      .adc_pwr_en(adc_pwr_en), .ref_pwr_en(ref_pwr_en), .busy(busy)
   );

   // converter stub and result monitor
   int res_ch[0:15], res_dat[0:15], res_cnv[0:15];
   int n_res = 0, conv_idx = 0, stub_cnt = 0, run = 0, last_run = 0, rises = 0;

   function automatic int smp(input int ch, input int i);
      return (ch * 331 + i * 157 + 40) % 4096;
   endfunction

   function automatic int exp_avg(input int ch, input int code);
      int n, sh, sum;
      n  = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
      sh = (code == 0) ? 0 : (code == 1) ? 2 : (code == 2) ? 3 : 4;
      sum = 0;
      for (int i = 0; i < n; i++) sum += smp(ch, i);
      return (sum >> sh) & 12'hFFF;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
               conv_done = 1'b1;
               conv_data = 12'(smp(int'(chan_sel), conv_idx));
               conv_idx++;
            end
         end
         if (conv_start) stub_cnt = 2;
         if (res_we && n_res < 16) begin
            res_ch[n_res]  = int'(res_chan);
            res_dat[n_res] = int'(res_data);
            res_cnv[n_res] = conv_idx;
            n_res++;
            conv_idx = 0;
         end
         if (sample_en) begin
            if (run == 0) rises++;
            run++;
         end else if (run > 0) begin
            last_run = run;
            run = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_start(input bit m);
      @(negedge clk);
      n_res = 0;
      start = 1'b1; start_master = m;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic gap_to_sample(output int n);
      n = 0;
      while (!sample_en) begin n++; @(negedge clk); end
   endtask

   task automatic wait_res();
      while (!res_we) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic tail_len(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic set_cfg(input int dly, input int acq, input int avg, input int pwr);
      cfg_delay_sel = 2'(dly); cfg_acq_sel = 2'(acq); cfg_avg_sel = 2'(avg); cfg_pwr_mode = 2'(pwr);
   endtask

   task automatic t_reset();
      chk("R11", "busy after reset", int'(busy), 0);
      chk("R6", "sample_en after reset", int'(sample_en), 0);
      chk("R6", "conv_start after reset", int'(conv_start), 0);
      chk("R11", "res_we after reset", int'(res_we), 0);
      chk("R8", "adc_pwr_en mode 00", int'(adc_pwr_en), 0);
      chk("R8", "ref_pwr_en mode 00", int'(ref_pwr_en), 0);
   endtask

   task automatic t_order_skip();
      int g;
      set_cfg(0, 0, 0, 1);
      slave_mask = 12'h903;   // channels 0, 3, 10 plus unused bit 0
      do_start(0);
      gap_to_sample(g);  chk("R2", "lead gap code 00", g, 2);
      wait_res(); gap_to_sample(g); chk("R1", "gap to channel 3", g, 1);
      wait_res(); gap_to_sample(g); chk("R1", "gap to channel 10", g, 1);
      wait_res(); tail_len(g); chk("R3", "tail code 00", g, 1);
      chk("R1", "result count", n_res, 3);
      chk("R1", "first channel", res_ch[0], 0);
      chk("R1", "second channel", res_ch[1], 3);
      chk("R1", "third channel", res_ch[2], 10);
      chk("R7", "single sample ch3", res_dat[1], exp_avg(3, 0));
      chk("R7", "single sample ch10", res_dat[2], exp_avg(10, 0));
   endtask

   task automatic t_coord_delay();
      int g;
      set_cfg(1, 0, 0, 1);
      slave_mask = 12'hE00;   // channels 0, 1, 2
      do_start(0);
      gap_to_sample(g);  chk("R2", "lead gap code 01", g, 257);
      wait_res(); gap_to_sample(g); chk("R3", "delay before channel 1", g, 257);
      wait_res(); gap_to_sample(g); chk("R3", "no delay before channel 2", g, 1);
      wait_res(); tail_len(g); chk("R3", "tail code 01", g, 256);
      chk("R1", "coord run results", n_res, 3);
      chk("R1", "channel 1 result", res_dat[1], exp_avg(1, 0));
   endtask

   task automatic t_delay_codes();
      int g;
      for (int c = 2; c < 4; c++) begin
         set_cfg(c, 0, 0, 1);
         slave_mask = 12'h040;   // channel 5
         do_start(0);
         gap_to_sample(g);
         chk("R2", $sformatf("lead gap code %0d", c), g, (c == 2) ? 2049 : 16385);
         wait_res(); tail_len(g);
         chk("R3", $sformatf("tail code %0d", c), g, (c == 2) ? 2048 : 16384);
      end
   endtask

   task automatic t_acq();
      for (int c = 0; c < 4; c++) begin
         set_cfg(0, c, 0, 1);
         slave_mask = 12'h040;
         do_start(0);
         wait_idle();
         chk("R6", $sformatf("window code %0d", c), last_run, 4 << c);
         chk("R6", "one conversion", res_cnv[0], 1);
      end
   endtask

   task automatic t_avg();
      set_cfg(0, 0, 1, 1);
      slave_mask = 12'h0A0;   // channels 4, 6
      do_start(0); wait_idle();
      chk("R7", "avg4 results", n_res, 2);
      chk("R7", "avg4 conversions", res_cnv[0], 4);
      chk("R7", "avg4 ch4", res_dat[0], exp_avg(4, 1));
      chk("R7", "avg4 ch6", res_dat[1], exp_avg(6, 1));
      set_cfg(0, 1, 2, 1);
      slave_mask = 12'h004;   // channel 9
      do_start(0); wait_idle();
      chk("R7", "avg8 conversions", res_cnv[0], 8);
      chk("R7", "avg8 ch9", res_dat[0], exp_avg(9, 2));
      set_cfg(0, 3, 3, 3);
      do_start(0); wait_idle();
      chk("R7", "avg16 conversions", res_cnv[0], 16);
      chk("R7", "avg16 ch9", res_dat[0], exp_avg(9, 3));
   endtask

   task automatic t_hold_pol();
      int r0;
      set_cfg(0, 0, 0, 1);
      slave_mask = 12'h040;
      cfg_hold_pol = 1'b0; hold_in = 1'b0;   // active low, asserted
      r0 = rises;
      do_start(0);
      repeat (100) @(negedge clk);
      chk("R4", "low-active hold blocks window", rises - r0, 0);
      chk("R4", "busy while held", int'(busy), 1);
      hold_in = 1'b1;
      wait_idle();
      chk("R4", "resumes after low-active release", n_res, 1);
      cfg_hold_pol = 1'b1; hold_in = 1'b1;   // active high, asserted
      r0 = rises;
      do_start(0);
      repeat (100) @(negedge clk);
      chk("R4", "high-active hold blocks window", rises - r0, 0);
      hold_in = 1'b0;
      wait_idle();
      chk("R4", "resumes after high-active release", n_res, 1);
   endtask

   task automatic t_hold_in_delay();
      int n;
      set_cfg(1, 0, 0, 1);
      slave_mask = 12'h040;
      cfg_hold_pol = 1'b1; hold_in = 1'b0;
      do_start(0);
      n = 0;
      while (!sample_en) begin
         n++;
         if (n == 50)  hold_in = 1'b1;
         if (n == 150) hold_in = 1'b0;
         @(negedge clk);
      end
      chk("R5", "hold pulse inside delay", n, 257);
      wait_idle();
   endtask

   task automatic t_power();
      set_cfg(0, 0, 0, 1); @(negedge clk);
      chk("R8", "mode 01 idle adc", int'(adc_pwr_en), 0);
      chk("R8", "mode 01 idle ref", int'(ref_pwr_en), 0);
      slave_mask = 12'h040;
      do_start(0);
      chk("R8", "mode 01 busy adc", int'(adc_pwr_en), 1);
      chk("R8", "mode 01 busy ref", int'(ref_pwr_en), 1);
      wait_idle();
      set_cfg(0, 0, 0, 3); @(negedge clk);
      chk("R8", "mode 11 idle adc", int'(adc_pwr_en), 0);
      chk("R8", "mode 11 idle ref", int'(ref_pwr_en), 1);
      do_start(0);
      chk("R8", "mode 11 busy adc", int'(adc_pwr_en), 1);
      wait_idle();
      set_cfg(0, 0, 0, 2); @(negedge clk);
      chk("R8", "mode 10 idle adc", int'(adc_pwr_en), 1);
      chk("R8", "mode 10 idle ref", int'(ref_pwr_en), 1);
      set_cfg(0, 0, 0, 0); @(negedge clk);
      chk("R8", "mode 00 adc", int'(adc_pwr_en), 0);
      chk("R8", "mode 00 ref", int'(ref_pwr_en), 0);
   endtask

   task automatic t_start_block();
      slave_mask = 12'h040; master_mask = 12'h040;
      set_cfg(0, 0, 0, 0);
      do_start(0); repeat (3) @(negedge clk);
      chk("R9", "mode 00 start ignored", int'(busy), 0);
      set_cfg(0, 0, 0, 2);
      do_start(1); repeat (3) @(negedge clk);
      chk("R9", "mode 10 master start ignored", int'(busy), 0);
      chk("R9", "mode 10 master no result", n_res, 0);
      do_start(0);
      chk("R9", "mode 10 slave start accepted", int'(busy), 1);
      wait_idle();
      chk("R9", "mode 10 slave result", n_res, 1);
      set_cfg(0, 0, 0, 1);
      slave_mask = 12'h001;   // only the unused bit
      do_start(0); repeat (3) @(negedge clk);
      chk("R11", "empty mask start ignored", int'(busy), 0);
   endtask

   task automatic t_masks();
      set_cfg(0, 0, 0, 3);
      slave_mask = 12'h040; master_mask = 12'h010;   // ch5 / ch7
      do_start(1); wait_idle();
      chk("R10", "master result count", n_res, 1);
      chk("R10", "master mask channel", res_ch[0], 7);
      do_start(0); wait_idle();
      chk("R10", "slave mask channel", res_ch[0], 5);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done_flag) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_skip();
      t_coord_delay();
      t_delay_codes();
      t_acq();
      t_avg();
      t_hold_pol();
      t_hold_in_delay();
      t_power();
      t_start_block();
      t_masks();
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule